// File: doc/BRIEF.md
# Four-Mode Logarithmic Barrel Shifter

This block moves a 16-bit word by 0 to 15 bit positions. It has no clock and no state. A 2-bit mode input selects one of four operations. Left rotate wraps bits from the top back to the bottom. Left shift brings zeros in from below. Arithmetic right shift copies the sign bit in from above. Logical right shift brings zeros in from above. It is meant to sit as the shift unit in the execute path of a datapath, between an operand mux and a result mux.

The word passes through a cascade of stages that move it by 1, 2, 4 and 8 positions. Each stage either moves the word or passes it through, under control of one bit of the shift amount, with bit 0 controlling the 1-position stage. In arithmetic mode every stage fills with bit 15 of the original operand. No stage takes its fill from the partly shifted word. Right rotate is not supported.

Top module: `bsh_shifter`

## Requirements
- R1: With mode_sel = 2'b00 the output is data_in rotated left by shift_amt positions. Bit i moves to bit (i + shift_amt) mod 16.
- R2: With mode_sel = 2'b01 the output is data_in shifted left by shift_amt positions, and the shift_amt lowest bits are zero.
- R3: With mode_sel = 2'b10 the output is data_in shifted right by shift_amt positions, and the shift_amt highest bits all equal data_in[15].
- R4: With mode_sel = 2'b11 the output is data_in shifted right by shift_amt positions, and the shift_amt highest bits are zero.
- R5: With shift_amt = 0 the output equals data_in in all four modes.
- R6: The largest amount, shift_amt = 15, is handled correctly in every mode. Rotate gives a right rotate by one. Left shift keeps only data_in[0], placed at bit 15. Arithmetic shift gives 16 copies of data_in[15]. Logical shift keeps only data_in[15], placed at bit 0.
- R7: The output is a pure function of the present inputs. It follows an input change within the same cycle, without any clock edge.
- R8: In rotate mode the output has the same number of one bits as data_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 16 | Operand to be moved |
| shift_amt | input | 4 | Unsigned number of positions, 0 to 15 |
| mode_sel | input | 2 | 00 rotate left, 01 shift left, 10 arithmetic right, 11 logical right |
| data_out | output | 16 | Shifted or rotated result |

## Verification
The block holds no state, so a wrong internal value is a wrong stage output, and it shows on data_out at once. A stage that ignores its amount bit produces errors only for amounts that have that bit set. For this reason every mode is swept over all 16 amounts. A fill taken from the partly shifted word instead of the original bit 15 shows up only in arithmetic mode, and only for combined amounts with a negative operand. Operands with a set sign bit and amounts such as 3, 12 and 15 are therefore included. A mixed-up mode decode shows up as the wrong fill or the wrong direction for the very first vector in that mode.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  typedef enum logic [1:0] {
    MODE_ROTL = 2'b00,
    MODE_SHL  = 2'b01,
    MODE_SRA  = 2'b10,
    MODE_SRL  = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/bsh_fill.sv
module bsh_fill
  import bsh_pkg::*;
(
  input  shift_mode_e mode,
  input  logic        sign_bit,
  output logic        fill_bit
);
  // Only the arithmetic mode brings in ones; every other mode brings in zero.
  always_comb begin
    fill_bit = (mode == MODE_SRA) ? sign_bit : 1'b0;
  end
endmodule

// File: rtl/bsh_stage.sv
module bsh_stage
  import bsh_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] d,
  input  logic             en,
  input  shift_mode_e      mode,
  input  logic             fill,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] moved;

  always_comb begin
    unique case (mode)
      MODE_ROTL: moved = {d[WIDTH-1-DIST:0], d[WIDTH-1:WIDTH-DIST]};
      MODE_SHL:  moved = {d[WIDTH-1-DIST:0], {DIST{1'b0}}};
      default:   moved = {{DIST{fill}}, d[WIDTH-1:DIST]};
    endcase
    q = en ? moved : d;
  end
endmodule

// File: rtl/bsh_shifter.sv
module bsh_shifter
  import bsh_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [AMT_W-1:0] shift_amt,
  input  logic [1:0]       mode_sel,
  output logic [WIDTH-1:0] data_out
);
  shift_mode_e      mode;
  logic             fill;
  logic [WIDTH-1:0] chain [0:AMT_W];

  assign mode     = shift_mode_e'(mode_sel);
  assign chain[0] = data_in;

  // The fill comes from the original operand, shared by all stages.
  bsh_fill u_fill (
    .mode     (mode),
    .sign_bit (data_in[WIDTH-1]),
    .fill_bit (fill)
  );

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    bsh_stage #(
      .WIDTH (WIDTH),
      .DIST  (1 << s)
    ) u_stage (
      .d    (chain[s]),
      .en   (shift_amt[s]),
      .mode (mode),
      .fill (fill),
      .q    (chain[s+1])
    );
  end

  assign data_out = chain[AMT_W];

  logic [WIDTH-1:0] low_mask;
  logic [WIDTH-1:0] high_mask;
  always_comb begin
    low_mask  = ~({WIDTH{1'b1}} << shift_amt);
    high_mask = ~({WIDTH{1'b1}} >> shift_amt);
    AST_ZERO_PASS: assert ((shift_amt != '0) || (data_out == data_in)); // R5
    AST_SHL_LOW_ZERO: assert ((mode != MODE_SHL) || ((data_out & low_mask) == '0)); // R2
    AST_SRL_HIGH_ZERO: assert ((mode != MODE_SRL) || ((data_out & high_mask) == '0)); // R4
    AST_SRA_HIGH_SIGN: assert ((mode != MODE_SRA) || ((data_out & high_mask) == (data_in[WIDTH-1] ? high_mask : '0))); // R3
    AST_ROT_ONES_KEPT: assert ((mode != MODE_ROTL) || ($countones(data_out) == $countones(data_in))); // R8
  end
endmodule

// File: tb/test_bsh_shifter.sv
module test_bsh_shifter;
  localparam int W = 16;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] din = '0;
  logic [3:0]   amt = '0;
  logic [1:0]   mode = '0;
  logic [W-1:0] dout;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bsh_shifter i_bsh_shifter (
    .data_in   (din),
    .shift_amt (amt),
    .mode_sel  (mode),
    .data_out  (dout)
  );

  // {mode, amt, operand, expected}
  localparam logic [37:0] VEC [NV] = '{
    {2'b00, 4'd4,  16'h1234, 16'h2341},
    {2'b00, 4'd15, 16'h8001, 16'hC000},
    {2'b01, 4'd3,  16'h00FF, 16'h07F8},
    {2'b01, 4'd15, 16'hFFFF, 16'h8000},
    {2'b10, 4'd4,  16'h8000, 16'hF800},
    {2'b10, 4'd15, 16'h8000, 16'hFFFF},
    {2'b10, 4'd8,  16'h7F00, 16'h007F},
    {2'b11, 4'd4,  16'h8000, 16'h0800},
    {2'b11, 4'd15, 16'hFFFF, 16'h0001},
    {2'b10, 4'd1,  16'hAAAA, 16'hD555},
    {2'b00, 4'd0,  16'hBEEF, 16'hBEEF},
    {2'b11, 4'd0,  16'hBEEF, 16'hBEEF}
  };

  function automatic logic [W-1:0] ref_model(input logic [W-1:0] x, input int a, input logic [1:0] m);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      case (m)
        2'b00: r[(i + a) % W] = x[i];
        2'b01: if (i + a < W) r[i + a] = x[i];
        2'b10: r[i] = (i + a < W) ? x[i + a] : x[W-1];
        default: r[i] = (i + a < W) ? x[i + a] : 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic [3:0] a);
    if (a == 4'd0) return "R5";
    if (a == 4'd15) return "R6";
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: mode=%b amt=%0d din=%h got %h expected %h", tag, mode, amt, din, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [3:0] a, input logic [W-1:0] x);
    @(negedge clk);
    mode = m; amt = a; din = x;
    #1;
  endtask

  localparam logic [W-1:0] OPS [8] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001,
                                       16'hA5C3, 16'h7FFE, 16'h9249, 16'hC0DE};

  initial begin
    #1;
    // Inputs all zero, so the output must be zero.
    check("R5", dout, 16'h0000);
    repeat (2) @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][37:36], VEC[v][35:32], VEC[v][31:16]);
      check(tag_of(VEC[v][37:36], VEC[v][35:32]), dout, VEC[v][15:0]);
    end

    // Sweep of every mode and every amount over a set of operands.
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 16; a++)
        for (int k = 0; k < 8; k++) begin
          apply(m[1:0], a[3:0], OPS[k]);
          check(tag_of(m[1:0], a[3:0]), dout, ref_model(OPS[k], a, m[1:0]));
          if (m == 0) begin
            n_cmp++;
            if ($countones(dout) != $countones(OPS[k])) begin
              n_bad++;
              $display("FAIL R8: ones got %0d expected %0d", $countones(dout), $countones(OPS[k]));
            end
          end
        end

    // R7: change the inputs between edges and sample before the next edge.
    @(posedge clk);
    #1;
    mode = 2'b11; amt = 4'd2; din = 16'hF00F;
    #1;
    check("R7", dout, 16'h3C03);
    din = 16'h0FF0;
    #1;
    check("R7", dout, 16'h03FC);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule